// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Bit-Bang Port

This block gives software a single control byte for driving a three-wire serial EEPROM over pins that it shares with a memory port. Software sets a request bit to ask for the pins. A small arbiter hands them over once the memory port is idle. From then on, the select, clock and data-out bits of the control byte appear on the EEPROM pins. The EEPROM's serial output is synchronised and read back in the lowest bit of the byte.

The ready bit has two jobs. When the pins are first granted, it rises at once. After every later write made while the pins are owned, it falls and stays low for a fixed pacing interval. That interval is derived from the clock frequency and an 800 ns target. Software polls the ready bit between clock edges of its bit-banged protocol. Clearing the request bit hands the pins back to the memory port on the next clock edge.

Top module: `eep_bitbang_port`

## Requirements
- R1: After reset, the read-back byte is 0x00, all three EEPROM output pins are low, and the memory port owns the shared pins (`mem_owns_pins` = 1).
- R2: The pins are granted only while the request bit (bit 5, 0x20) is set and `mem_busy` is low. The grant is taken on the clock edge after the request is registered. While `mem_busy` stays high, or the request bit is clear, no grant happens.
- R3: On the edge that grants the pins, the ready bit (bit 4, 0x10) becomes 1 with no pacing delay.
- R4: While granted, `ee_cs`, `ee_sk` and `ee_di` follow the select (bit 3, 0x08), clock (bit 2, 0x04) and data-out (bit 1, 0x02) register bits. The read-back byte shows request, ready, select, clock, data-out and data-in at those bit positions, with bits 7:6 reading 0.
- R5: While not granted, the EEPROM output pins stay low and the data-in bit (bit 0, 0x01) reads 0, whatever the register bits and `ee_do` hold.
- R6: A write with the request bit set, made while granted, clears ready. Ready then reads 0 for exactly PACE clock edges after the write edge and returns to 1 on the PACE-th edge. PACE = ceil(CLK_MHZ × PACE_NS / 1000), which is 80 with the defaults.
- R7: A write made while the pacing interval is running restarts the full interval from that write.
- R8: A write with the request bit clear releases the pins on its own edge: ready reads 0, the EEPROM pins go low and `mem_owns_pins` returns to 1.
- R9: The data-in bit shows `ee_do` through two flip-flops. A change on `ee_do` is invisible after one clock edge and visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Writes `wr_data` into the control byte this cycle |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control byte read-back |
| mem_busy | input | 1 | Memory port is busy with another request |
| mem_owns_pins | output | 1 | High while the memory port keeps the shared pins |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM (asynchronous) |

## Verification
The assertions assume that `mem_busy` and the write strobe are synchronous to `clk`. They also assume that once the pins are granted, the memory port does not take them back on its own; only a release write does. The bench changes every input at the falling edge and holds `mem_busy` high only before a grant. It toggles `ee_do` only while it is counting synchroniser stages, so each expected edge count is exact.

// File: rtl/eep_port_pkg.sv
package eep_port_pkg;
  localparam int BIT_REQ = 5;
  localparam int BIT_RDY = 4;
  localparam int BIT_CS  = 3;
  localparam int BIT_SK  = 2;
  localparam int BIT_DO  = 1;
  localparam int BIT_DI  = 0;

  // Pacing interval in clock cycles, rounded up.
  function automatic int pace_cycles(input int clk_mhz, input int pace_ns);
    return (clk_mhz * pace_ns + 999) / 1000;
  endfunction
endpackage

// File: rtl/eep_arbiter.sv
module eep_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req_q,
  input  logic mem_busy,
  input  logic release_evt,
  output logic owned,
  output logic grant_evt
);
  assign grant_evt = req_q && !owned && !mem_busy && !release_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           owned <= 1'b0;
    else if (release_evt) owned <= 1'b0;
    else if (grant_evt)   owned <= 1'b1;
  end
endmodule

// File: rtl/eep_pace_timer.sv
module eep_pace_timer #(
  parameter int CYCLES = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clear)       cnt <= '0;
    else if (restart)     cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eep_bitbang_port.sv
module eep_bitbang_port
  import eep_port_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int PACE_NS     = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       mem_busy,
  output logic       mem_owns_pins,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di,
  input  logic       ee_do
);
  localparam int PACE = pace_cycles(CLK_MHZ, PACE_NS);

  logic req_q, cs_q, sk_q, do_q;
  logic owned, grant_evt, release_evt, restart_evt;
  logic pace_done, ready, din_sync;

  assign release_evt = wr_en && !wr_data[BIT_REQ];
  assign restart_evt = wr_en &&  wr_data[BIT_REQ] && owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cs_q  <= 1'b0;
      sk_q  <= 1'b0;
      do_q  <= 1'b0;
    end else if (wr_en) begin
      req_q <= wr_data[BIT_REQ];
      cs_q  <= wr_data[BIT_CS];
      sk_q  <= wr_data[BIT_SK];
      do_q  <= wr_data[BIT_DO];
    end
  end

  eep_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_q      (req_q),
    .mem_busy   (mem_busy),
    .release_evt(release_evt),
    .owned      (owned),
    .grant_evt  (grant_evt)
  );

  eep_pace_timer #(.CYCLES(PACE)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (release_evt),
    .restart(restart_evt),
    .expired(pace_done)
  );

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ee_do),
    .q    (din_sync)
  );

  assign ready         = owned && pace_done;
  assign mem_owns_pins = !owned;
  assign ee_cs         = owned && cs_q;
  assign ee_sk         = owned && sk_q;
  assign ee_di         = owned && do_q;

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_REQ] = req_q;
    rd_data[BIT_RDY] = ready;
    rd_data[BIT_CS]  = cs_q;
    rd_data[BIT_SK]  = sk_q;
    rd_data[BIT_DO]  = do_q;
    rd_data[BIT_DI]  = owned && din_sync;
  end
endmodule

// File: rtl/eep_bitbang_port_chk.sv
module eep_bitbang_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       mem_busy,
  input logic       mem_owns_pins,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di
);
  logic owned;
  assign owned = !mem_owns_pins;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == 8'h00) || !rst_n);

  assert_grant_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned) |-> $past(!mem_busy && rd_data[5]));

  assert_ready_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned) |-> rd_data[4]);

  assert_pins_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !owned |-> (!ee_cs && !ee_sk && !ee_di && !rd_data[0] && !rd_data[4]));

  assert_pace_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5] && owned) |=> (owned && !rd_data[4]));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[5]) |=> (!owned && !rd_data[4]));

  assert_pins_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    owned |-> (ee_cs == rd_data[3] && ee_sk == rd_data[2] && ee_di == rd_data[1]));
endmodule

bind eep_bitbang_port eep_bitbang_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .mem_busy     (mem_busy),
  .mem_owns_pins(mem_owns_pins),
  .ee_cs        (ee_cs),
  .ee_sk        (ee_sk),
  .ee_di        (ee_di)
);

// File: tb/eep_bitbang_port_tb.sv
module eep_bitbang_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PACE = (100 * 800 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       mem_busy = 1'b1;
  logic       mem_owns_pins;
  logic       ee_cs, ee_sk, ee_di;
  logic       ee_do = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_bitbang_port dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .mem_busy     (mem_busy),
    .mem_owns_pins(mem_owns_pins),
    .ee_cs        (ee_cs),
    .ee_sk        (ee_sk),
    .ee_di        (ee_di),
    .ee_do        (ee_do)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic pins(input string req, input logic own, input logic [2:0] exp);
    chk(req, {4'b0, mem_owns_pins, ee_cs, ee_sk, ee_di}, {4'b0, !own, exp});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 readback", rd_data, 8'h00);
    pins("R1 pins", 1'b0, 3'b000);
  endtask

  task automatic t_blocked;
    mem_busy = 1'b1;
    wr(8'h2E);
    chk("R5 readback no grant", rd_data, 8'h2E);
    pins("R5 pins idle", 1'b0, 3'b000);
    step(5);
    pins("R2 busy blocks grant", 1'b0, 3'b000);
    ee_do = 1'b1;
    step(3);
    chk("R5 din gated", rd_data, 8'h2E);
  endtask

  task automatic t_grant;
    mem_busy = 1'b0;
    step(1);
    chk("R3 ready on grant", rd_data, 8'h3F);
    pins("R4 pins follow", 1'b1, 3'b111);
  endtask

  task automatic t_pace;
    wr(8'h28);
    chk("R6 ready drops", rd_data, 8'h29);
    pins("R4 pins cs only", 1'b1, 3'b100);
    step(PACE - 1);
    chk("R6 still pacing", rd_data, 8'h29);
    step(1);
    chk("R6 ready back", rd_data, 8'h39);
  endtask

  task automatic t_restart;
    wr(8'h20);
    step(10);
    chk("R7 mid interval", rd_data, 8'h21);
    wr(8'h24);
    pins("R4 clock pin", 1'b1, 3'b010);
    step(PACE - 1);
    chk("R7 restarted", rd_data, 8'h25);
    step(1);
    chk("R7 ready after restart", rd_data, 8'h35);
  endtask

  task automatic t_din;
    ee_do = 1'b0;
    step(1);
    chk("R9 one stage", rd_data, 8'h35);
    step(1);
    chk("R9 two stages", rd_data, 8'h34);
    ee_do = 1'b1;
    step(2);
    chk("R9 rise seen", rd_data, 8'h35);
  endtask

  task automatic t_release;
    wr(8'h0E);
    chk("R8 readback", rd_data, 8'h0E);
    pins("R8 pins released", 1'b0, 3'b000);
    step(4);
    pins("R2 no request no grant", 1'b0, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_blocked();
    t_grant();
    t_pace();
    t_restart();
    t_din();
    t_release();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule